// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt request lines (32 by default) and presents them to a processor as a single request line. Each request line first passes through a two-flop synchronizer. The synchronized levels form a pending register that follows the inputs directly. No edges are latched, and nothing needs to be acknowledged or cleared. A software-written enable mask, in which a 1 enables its source, is ANDed with the pending register. The registered OR of that product drives the processor request.

Software reaches the block through a plain 32-bit word register port. The port has a byte address, a write enable, write data, and registered read data. The enable mask is read/write at byte offset 0x04. The pending register is read-only at byte offset 0x0C. Every other offset reads as zero and ignores writes, and so does any address that is not word aligned. Bits above the configured source count read as zero.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable mask, the pending register, the read data and `irqOut` are all zero.
- R2: Pending bit i is 1 while request line i is high and 0 once it is low. A change on a line is visible in the pending register two clock edges after it is sampled.
- R3: `irqOut` is 1 exactly when (mask AND pending) is nonzero. It is a register and updates one clock edge after the mask or the pending register changes.
- R4: The enable mask is written at byte offset 0x04 on the clock edge where `busWrEn` is sampled high, and it reads back from 0x04. A mask bit of 1 enables its source and a 0 blocks it.
- R5: The pending register reads at byte offset 0x0C. A write to 0x0C changes neither the pending register nor the mask.
- R6: Writes to offsets 0x00 and 0x14, to any other unlisted offset, and to any address whose two low bits are nonzero change no state.
- R7: Reads of any address other than 0x04 and 0x0C, including misaligned addresses, return zero.
- R8: Read data for the address presented in one cycle appears on `busRdData` after the next clock edge.
- R9: With fewer than 32 sources, the mask and pending bits above the source count read as zero. Write data on those bit positions is dropped.
- R10: A mask write and a request-line change in the same cycle are both honoured. `irqOut` first follows the new mask against the old pending value, then the new mask against the new pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Level-sensitive interrupt request lines |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe; the write happens on the clock edge where it is high |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data for the previous cycle's address |
| irqOut | output | 1 | Combined interrupt request to the processor |

## Verification
Two events can land on the same clock edge: a software write to the enable mask and a change on the request lines. The bench provokes this by driving a new mask and a new input pattern in the same cycle, with the old and new patterns chosen so that each combination gives a different output. It then compares `irqOut` edge by edge against the old-mask/old-pending, new-mask/old-pending and new-mask/new-pending products. Exhaustive sweeps of all input patterns against several masks, and of all masks against several patterns, judge the AND/OR reduction arithmetically.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  // Register offsets (byte addresses, word aligned)
  localparam int unsigned MASK_OFS = 32'h04;
  localparam int unsigned PEND_OFS = 32'h0C;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic wrMask;   // load the enable mask this edge
    logic selMask;  // current address selects the mask for reading
    logic selPend;  // current address selects the pending register for reading
  } ctlStrobe_t;

endpackage

// File: rtl/lvl_irq_ctrl_ctl.sv
module lvl_irq_ctrl_ctl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobe_t        strobe
);

  logic aligned;
  logic hitMask;
  logic hitPend;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    hitMask = aligned && (busAddr == ADDR_W'(MASK_OFS));
    hitPend = aligned && (busAddr == ADDR_W'(PEND_OFS));
    strobe.selMask = hitMask;
    strobe.selPend = hitPend;
    // Only the mask is writable; every other offset is a silent no-op
    strobe.wrMask  = busWrEn && hitMask;
  end

  // R7: at most one read source is selected
  assert_sel_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selMask, strobe.selPend}));

  // R6: a misaligned address never produces a write
  assert_no_misaligned_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> !strobe.wrMask);

endmodule

// File: rtl/lvl_irq_ctrl_dp.sv
module lvl_irq_ctrl_dp
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [DATA_W-1:0]  busWrData,
  input  ctlStrobe_t         strobe,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);

  localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] pendingQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [DATA_W-1:0]  rdNext;
  logic [DATA_W-1:0]  rdDataQ;
  logic               irqOutQ;
  logic               unusedWrBits;

  assign unusedWrBits = ^busWrData;

  // Input synchronizer chain; the last stage is the pending register
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[s] <= '0;
        end else if (s == 0) begin
          syncQ[s] <= irqIn;
        end else begin
          syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign pendingQ = syncQ[SYNC_STAGES-1];

  // Enable mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.wrMask) begin
      maskQ <= busWrData[NUM_SRC-1:0];
    end
  end

  // Registered request output, re-evaluated every cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOutQ <= 1'b0;
    end else begin
      irqOutQ <= |(maskQ & pendingQ);
    end
  end

  // Read mux, zero-extended to the bus width
  always_comb begin
    rdNext = '0;
    if (strobe.selMask) begin
      rdNext[NUM_SRC-1:0] = maskQ;
    end else if (strobe.selPend) begin
      rdNext[NUM_SRC-1:0] = pendingQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else begin
      rdDataQ <= rdNext;
    end
  end

  assign busRdData = rdDataQ;
  assign irqOut    = irqOutQ;

  // ---------------- assertions ----------------
  logic [CNT_W-1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt <= '0;
    end else if (upCnt != CNT_W'(SYNC_STAGES)) begin
      upCnt <= upCnt + 1'b1;
    end
  end

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      // R2: pending mirrors the input level two edges later
      assert_pend_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt == CNT_W'(SYNC_STAGES)) |-> (pendingQ == $past(irqIn, 2)));
    end
  endgenerate

  // R3: output raised after an enabled pending source
  assert_out_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ & pendingQ) != '0) |=> irqOut);

  // R3: output low when nothing enabled is pending
  assert_out_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ & pendingQ) == '0) |=> !irqOut);

  // R4: mask takes the written data
  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> (maskQ == $past(busWrData[NUM_SRC-1:0])));

  // R5/R6: without a mask write the mask holds
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMask |=> $stable(maskQ));

  // R7: unmapped reads return zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.selMask || strobe.selPend) |=> (busRdData == '0));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               irqOut
);

  ctlStrobe_t strobe;

  lvl_irq_ctrl_ctl #(
    .ADDR_W (ADDR_W)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  lvl_irq_ctrl_dp #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (32)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;

  localparam int unsigned NSRC = 8;
  localparam int unsigned AW   = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] irqIn = '0;
  logic [AW-1:0]   busAddr = '0;
  logic            busWrEn = 1'b0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic            irqOut;

  int vectors = 0;
  int miscompares = 0;
  logic [NSRC-1:0] expMask = '0;
  logic [NSRC-1:0] curIrq = '0;

  always #5 clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    @(negedge clk);
    d = busRdData;
  endtask

  task automatic setIrq(input logic [NSRC-1:0] v);
    @(negedge clk);
    irqIn = v; curIrq = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [NSRC-1:0] masks [6] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80};
    logic [NSRC-1:0] pats  [4] = '{8'h00, 8'hFF, 8'h3C, 8'h81};

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 irqOut in reset", {31'b0, irqOut}, 32'h0);
    check("R1 rdData in reset", busRdData, 32'h0);
    rstN = 1'b1;
    irqIn = 8'hFF;
    @(negedge clk);
    irqIn = '0;
    busRead(8'h04, rd); check("R1 mask after reset", rd, 32'h0);
    busRead(8'h0C, rd); check("R1 pending after reset", rd, 32'h0);

    // R2/R3: all input patterns against several masks
    foreach (masks[mi]) begin
      busWrite(8'h04, {24'h0, masks[mi]}); expMask = masks[mi];
      for (int v = 0; v < 256; v++) begin
        setIrq(NSRC'(v));
        check("R3 irqOut sweep", {31'b0, irqOut}, {31'b0, |(expMask & NSRC'(v))});
        busRead(8'h0C, rd);
        check("R2 pending sweep", rd, 32'(v));
      end
    end

    // R4/R9: all masks against several patterns, upper write bits junk
    foreach (pats[pi]) begin
      setIrq(pats[pi]);
      for (int m = 0; m < 256; m++) begin
        busWrite(8'h04, {24'hA5C3E7 ^ 24'(m), 8'(m)}); expMask = NSRC'(m);
        @(negedge clk);
        check("R4 irqOut after mask write", {31'b0, irqOut}, {31'b0, |(expMask & pats[pi])});
        busRead(8'h04, rd);
        check("R9 mask readback upper zero", rd, 32'(m));
      end
    end

    // R2: line going low clears its pending bit
    setIrq(8'h24);
    setIrq(8'h04);
    busRead(8'h0C, rd); check("R2 pending clears on low", rd, 32'h04);

    // R8: read latency of one edge
    @(negedge clk); busAddr = 8'h04;
    @(negedge clk); check("R8 read one edge later", busRdData, {24'h0, expMask});
    busAddr = 8'h10;
    @(negedge clk); check("R8 read follows address", busRdData, 32'h0);

    // R5/R6: writes everywhere but the mask offset change nothing
    busWrite(8'h04, 32'h0000_005A); expMask = 8'h5A;
    setIrq(8'h33);
    for (int a = 0; a < 256; a++) begin
      if (a != 4) busWrite(AW'(a), 32'hFFFF_FFA5 ^ 32'(a));
    end
    busRead(8'h04, rd); check("R6 mask untouched by other writes", rd, 32'h5A);
    busRead(8'h0C, rd); check("R5 pending read only", rd, 32'h33);
    busWrite(8'h0C, 32'h0);
    busRead(8'h0C, rd); check("R5 pending after write to 0x0C", rd, 32'h33);
    busWrite(8'h00, 32'hFF); busWrite(8'h14, 32'hFF); busWrite(8'h05, 32'hFF);
    busRead(8'h04, rd); check("R6 mask after 0x00/0x14/0x05 writes", rd, 32'h5A);
    check("R6 irqOut unchanged", {31'b0, irqOut}, {31'b0, |(8'h5A & 8'h33)});

    // R7: read every address
    for (int a = 0; a < 256; a++) begin
      busRead(AW'(a), rd);
      check("R7 read map", rd, (a == 4) ? 32'h5A : (a == 12) ? 32'h33 : 32'h0);
    end

    // R10: mask write and input change in the same cycle
    busWrite(8'h04, 32'h0F); expMask = 8'h0F;
    setIrq(8'h0F);
    check("R10 before", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    busAddr = 8'h04; busWrEn = 1'b1; busWrData = 32'hF0; irqIn = 8'hF0;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R10 edge1 old mask old pending", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R10 edge2 new mask old pending", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R10 edge3 new mask new pending", {31'b0, irqOut}, 32'h1);

    // R1: reset in mid-run clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 irqOut on reset", {31'b0, irqOut}, 32'h0);
    irqIn = '0; rstN = 1'b1;
    busRead(8'h04, rd); check("R1 mask cleared by reset", rd, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule